// File: doc/BRIEF.md
# DMA Burst Address Sequencer

This block produces the read and write address stream for a single DMA transfer unit. Software first sets a control word that holds the unit size, the address mode for each side and two burst-repeat flags. It then loads a source base and a destination base while the block is idle. A one-cycle start pulse launches the unit. The block issues every read address of the unit, one beat per accepted handshake, and then every write address. When the last write is accepted, it moves each base to its next value according to that side's mode and raises a done pulse.

Units of 1, 2 or 4 bytes take one beat on each side. A 16-byte unit takes four 32-bit beats on each side. On a side whose mode is fixed, the repeat flag picks how those beats are addressed. With the flag clear, the beats walk the four word slots of the aligned 16-byte block. With the flag set, all four beats go to the unchanged base, which suits a single data-port register. The two sides choose independently.

Top module: `dma_burst_addr_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, both valids, `ctrl_rdata` and both bases are all 0.
- R2: The control word uses these fields: bits [1:0] size, [3:2] source mode, [5:4] destination mode, bit 8 source repeat flag, bit 9 destination repeat flag. Bit 10 is reserved, and bits 7:6 and 15:11 are unused. All of these other bits read back as 0 whatever value was written to them.
- R3: Size codes are 0=1 byte, 1=2 bytes and 2=4 bytes. Each of these units is one read beat and one write beat, both at the unmodified base.
- R4: Size code 3 means 16 bytes. A side that steps issues four beats at A, A+4, A+8 and A+C, where A is the base with bits [3:0] cleared. A side steps when its mode is increment or decrement, or when its mode is fixed and its repeat flag is clear.
- R5: With size 16, fixed mode (code 0) and the side's repeat flag set, that side issues four beats, all at the unaltered base.
- R6: A repeat flag has no effect unless the size is 16 and that side's mode is fixed.
- R7: The source and destination repeat behaviours are independent of each other.
- R8: All reads of a unit are issued before any write. `rd_valid` and `wr_valid` are never high together. A pending address stays valid and unchanged until it is accepted.
- R9: `done` is high for exactly the one cycle after the last write is accepted. `busy` is high from the cycle after an accepted start until `done` falls.
- R10: Bases load from `src_base_in`/`dst_base_in` when `base_we` is high while idle. At the end of a unit, mode 1 (increment) adds the unit size and mode 2 (decrement) subtracts it; on a stepping 16-byte side this is applied to the aligned base. Fixed mode leaves the base unchanged.
- R11: While the block is busy, a start pulse or a `base_we` pulse has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_we | input | 1 | Write strobe for the control word |
| ctrl_wdata | input | 16 | Control word write value |
| ctrl_rdata | output | 16 | Control word read-back |
| base_we | input | 1 | Load both bases (only when idle) |
| src_base_in | input | 32 | Source base load value |
| dst_base_in | input | 32 | Destination base load value |
| src_base | output | 32 | Current source base |
| dst_base | output | 32 | Current destination base |
| start | input | 1 | Start pulse for one unit |
| busy | output | 1 | Unit in progress |
| rd_valid | output | 1 | Read address valid |
| rd_ready | input | 1 | Read address accepted |
| rd_addr | output | 32 | Read address |
| wr_valid | output | 1 | Write address valid |
| wr_ready | input | 1 | Write address accepted |
| wr_addr | output | 32 | Write address |
| done | output | 1 | Unit-complete pulse |

## Verification
The hardest state to reach is a 16-byte unit where one side repeats a fixed word while the other side walks an unaligned base. The beat counter must advance only on accepted handshakes that the bench delays at random, and start and base-write pulses arrive in the middle of the unit. The stimulus draws the size, modes, flags, bases and ready patterns at random from a fixed seed, and in one unit out of three it injects a start and a garbage base load during the unit. Directed units pin down unaligned stepping, decrement across the alignment boundary, repeat flags combined with small sizes or non-fixed modes, and mixed repeat/step pairs.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  localparam int ADDR_W      = 32;
  localparam int BEAT_W      = 2;
  localparam int WORD_SHIFT  = 2;
  localparam int BURST_LOG2  = 4;

  typedef enum logic [1:0] {
    SZ_1  = 2'd0,
    SZ_2  = 2'd1,
    SZ_4  = 2'd2,
    SZ_16 = 2'd3
  } xfer_size_e;

  typedef enum logic [1:0] {
    AM_FIXED = 2'd0,
    AM_INC   = 2'd1,
    AM_DEC   = 2'd2,
    AM_RSV   = 2'd3
  } addr_mode_e;

  typedef struct packed {
    logic       dst_rep;
    logic       src_rep;
    addr_mode_e dst_mode;
    addr_mode_e src_mode;
    xfer_size_e size;
  } seq_cfg_t;

  function automatic logic mode_is_fixed(addr_mode_e m);
    return (m == AM_FIXED) || (m == AM_RSV);
  endfunction

  function automatic logic side_repeats(xfer_size_e s, addr_mode_e m, logic rep);
    return (s == SZ_16) && mode_is_fixed(m) && rep;
  endfunction

  function automatic logic side_steps(xfer_size_e s, addr_mode_e m, logic rep);
    return (s == SZ_16) && !side_repeats(s, m, rep);
  endfunction

  function automatic logic [ADDR_W-1:0] unit_bytes(xfer_size_e s);
    case (s)
      SZ_1:    return ADDR_W'(1);
      SZ_2:    return ADDR_W'(2);
      SZ_4:    return ADDR_W'(4);
      default: return ADDR_W'(1) << BURST_LOG2;
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] align_burst(logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:BURST_LOG2], {BURST_LOG2{1'b0}}};
  endfunction

  function automatic logic [BEAT_W-1:0] last_beat(xfer_size_e s);
    return (s == SZ_16) ? {BEAT_W{1'b1}} : {BEAT_W{1'b0}};
  endfunction

  function automatic logic [ADDR_W-1:0] beat_address(logic [ADDR_W-1:0] base,
                                                     xfer_size_e s, addr_mode_e m,
                                                     logic rep, logic [BEAT_W-1:0] beat);
    if (side_steps(s, m, rep))
      return align_burst(base) | (ADDR_W'(beat) << WORD_SHIFT);
    return base;
  endfunction

  function automatic logic [ADDR_W-1:0] next_base(logic [ADDR_W-1:0] base,
                                                  xfer_size_e s, addr_mode_e m,
                                                  logic rep);
    logic [ADDR_W-1:0] origin;
    origin = side_steps(s, m, rep) ? align_burst(base) : base;
    case (m)
      AM_INC:  return origin + unit_bytes(s);
      AM_DEC:  return origin - unit_bytes(s);
      default: return base;
    endcase
  endfunction

endpackage

// File: rtl/dma_seq_regs.sv
module dma_seq_regs
  import dma_seq_pkg::*;
#(
  parameter int CTRL_W    = 16,
  parameter int SREP_BIT  = 8,
  parameter int DREP_BIT  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  output logic [CTRL_W-1:0] ctrl_rdata,
  output seq_cfg_t          cfg,
  input  logic              base_we,
  input  logic              seq_idle,
  input  logic [ADDR_W-1:0] src_base_in,
  input  logic [ADDR_W-1:0] dst_base_in,
  input  logic              unit_done,
  input  logic [ADDR_W-1:0] src_next,
  input  logic [ADDR_W-1:0] dst_next,
  output logic [ADDR_W-1:0] src_base,
  output logic [ADDR_W-1:0] dst_base
);

  // Writable bits: size, both modes, both repeat flags; everything else is tied low.
  localparam logic [CTRL_W-1:0] CTRL_MASK =
      CTRL_W'(6'h3F) | (CTRL_W'(1) << SREP_BIT) | (CTRL_W'(1) << DREP_BIT);

  logic [CTRL_W-1:0] ctrl_q;
  logic              base_load;

  assign base_load = base_we && seq_idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else if (ctrl_we) ctrl_q <= ctrl_wdata & CTRL_MASK;
  end

  assign ctrl_rdata   = ctrl_q;
  assign cfg.size     = xfer_size_e'(ctrl_q[1:0]);
  assign cfg.src_mode = addr_mode_e'(ctrl_q[3:2]);
  assign cfg.dst_mode = addr_mode_e'(ctrl_q[5:4]);
  assign cfg.src_rep  = ctrl_q[SREP_BIT];
  assign cfg.dst_rep  = ctrl_q[DREP_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_base <= '0;
      dst_base <= '0;
    end else if (unit_done) begin
      src_base <= src_next;
      dst_base <= dst_next;
    end else if (base_load) begin
      src_base <= src_base_in;
      dst_base <= dst_base_in;
    end
  end

  // R11: bases cannot move while a unit runs, except at its completion.
  p_base_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!seq_idle && !unit_done) |=> ($stable(src_base) && $stable(dst_base)));

endmodule

// File: rtl/dma_seq_side.sv
module dma_seq_side
  import dma_seq_pkg::*;
(
  input  logic [ADDR_W-1:0] base,
  input  xfer_size_e        size,
  input  addr_mode_e        mode,
  input  logic              rep,
  input  logic [BEAT_W-1:0] beat,
  output logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] next,
  output logic              steps
);

  assign addr  = beat_address(base, size, mode, rep, beat);
  assign next  = next_base(base, size, mode, rep);
  assign steps = side_steps(size, mode, rep);

endmodule

// File: rtl/dma_seq_beat_fsm.sv
module dma_seq_beat_fsm
  import dma_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BEAT_W-1:0] last,
  input  logic              rd_ready,
  input  logic              wr_ready,
  output logic              rd_valid,
  output logic              wr_valid,
  output logic [BEAT_W-1:0] beat,
  output logic              busy,
  output logic              done,
  output logic              start_accept,
  output logic              unit_done
);

  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR, ST_FIN} seq_state_e;

  seq_state_e state;
  logic       rd_step, wr_step, beat_last;

  assign rd_valid     = (state == ST_RD);
  assign wr_valid     = (state == ST_WR);
  assign busy         = (state != ST_IDLE);
  assign done         = (state == ST_FIN);
  assign rd_step      = rd_valid && rd_ready;
  assign wr_step      = wr_valid && wr_ready;
  assign beat_last    = (beat == last);
  assign start_accept = (state == ST_IDLE) && start;
  assign unit_done    = wr_step && beat_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      beat  <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          state <= ST_RD;
          beat  <= '0;
        end
        ST_RD: if (rd_step) begin
          if (beat_last) begin
            state <= ST_WR;
            beat  <= '0;
          end else begin
            beat <= beat + 1'b1;
          end
        end
        ST_WR: if (wr_step) begin
          if (beat_last) begin
            state <= ST_FIN;
            beat  <= '0;
          end else begin
            beat <= beat + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_rd_wr_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_valid && wr_valid));

  p_rd_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> rd_valid);

  p_wr_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> wr_valid);

  p_done_after_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    unit_done |=> (done && busy));

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

endmodule

// File: rtl/dma_burst_addr_seq.sv
module dma_burst_addr_seq
  import dma_seq_pkg::*;
#(
  parameter int CTRL_W   = 16,
  parameter int SREP_BIT = 8,
  parameter int DREP_BIT = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  output logic [CTRL_W-1:0] ctrl_rdata,
  input  logic              base_we,
  input  logic [ADDR_W-1:0] src_base_in,
  input  logic [ADDR_W-1:0] dst_base_in,
  output logic [ADDR_W-1:0] src_base,
  output logic [ADDR_W-1:0] dst_base,
  input  logic              start,
  output logic              busy,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              done
);

  localparam int N_SIDES = 2;   // index 0 = source, 1 = destination
  localparam int SRC     = 0;
  localparam int DST     = 1;

  seq_cfg_t          cfg_live, cfg_act;
  logic              start_accept, unit_done;
  logic [BEAT_W-1:0] beat;

  logic [ADDR_W-1:0] side_base [N_SIDES];
  addr_mode_e        side_mode [N_SIDES];
  logic              side_rep  [N_SIDES];
  logic [ADDR_W-1:0] side_addr [N_SIDES];
  logic [ADDR_W-1:0] side_next [N_SIDES];
  logic              side_step [N_SIDES];

  dma_seq_regs #(
    .CTRL_W   (CTRL_W),
    .SREP_BIT (SREP_BIT),
    .DREP_BIT (DREP_BIT)
  ) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctrl_we     (ctrl_we),
    .ctrl_wdata  (ctrl_wdata),
    .ctrl_rdata  (ctrl_rdata),
    .cfg         (cfg_live),
    .base_we     (base_we),
    .seq_idle    (!busy),
    .src_base_in (src_base_in),
    .dst_base_in (dst_base_in),
    .unit_done   (unit_done),
    .src_next    (side_next[SRC]),
    .dst_next    (side_next[DST]),
    .src_base    (src_base),
    .dst_base    (dst_base)
  );

  // Configuration is frozen for the life of a unit.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_act <= '0;
    else if (start_accept) cfg_act <= cfg_live;
  end

  always_comb begin
    side_base[SRC] = src_base;
    side_base[DST] = dst_base;
    side_mode[SRC] = cfg_act.src_mode;
    side_mode[DST] = cfg_act.dst_mode;
    side_rep[SRC]  = cfg_act.src_rep;
    side_rep[DST]  = cfg_act.dst_rep;
  end

  for (genvar s = 0; s < N_SIDES; s++) begin : g_side
    dma_seq_side u_side (
      .base  (side_base[s]),
      .size  (cfg_act.size),
      .mode  (side_mode[s]),
      .rep   (side_rep[s]),
      .beat  (beat),
      .addr  (side_addr[s]),
      .next  (side_next[s]),
      .steps (side_step[s])
    );
  end

  dma_seq_beat_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .last         (last_beat(cfg_act.size)),
    .rd_ready     (rd_ready),
    .wr_ready     (wr_ready),
    .rd_valid     (rd_valid),
    .wr_valid     (wr_valid),
    .beat         (beat),
    .busy         (busy),
    .done         (done),
    .start_accept (start_accept),
    .unit_done    (unit_done)
  );

  assign rd_addr = side_addr[SRC];
  assign wr_addr = side_addr[DST];

  p_rd_addr_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> $stable(rd_addr));

  p_wr_addr_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> $stable(wr_addr));

  p_src_repeat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready && cfg_act.size == SZ_16 && !side_step[SRC])
      |=> (!rd_valid || $stable(rd_addr)));

  p_src_step_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready && side_step[SRC] && beat != last_beat(cfg_act.size))
      |=> (rd_addr == $past(rd_addr) + ADDR_W'(4)));

  p_dst_step_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && side_step[DST] && beat != last_beat(cfg_act.size))
      |=> (wr_addr == $past(wr_addr) + ADDR_W'(4)));

  p_start_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_valid || wr_valid) && start) |=> busy);

endmodule

// File: tb/test_dma_burst_addr_seq.sv
`timescale 1ns/1ps
module test_dma_burst_addr_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_we = 1'b0;
  logic [15:0] ctrl_wdata = '0;
  logic [15:0] ctrl_rdata;
  logic        base_we = 1'b0;
  logic [31:0] src_base_in = '0, dst_base_in = '0;
  logic [31:0] src_base, dst_base;
  logic        start = 1'b0;
  logic        busy, rd_valid, wr_valid, done;
  logic        rd_ready = 1'b0, wr_ready = 1'b0;
  logic [31:0] rd_addr, wr_addr;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  dma_burst_addr_seq i_dma_burst_addr_seq (
    .clk, .rst_n, .ctrl_we, .ctrl_wdata, .ctrl_rdata, .base_we,
    .src_base_in, .dst_base_in, .src_base, .dst_base, .start, .busy,
    .rd_valid, .rd_ready, .rd_addr, .wr_valid, .wr_ready, .wr_addr, .done
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Bench restatement of the address rules.
  function automatic bit holds(bit [1:0] sz, bit [1:0] md, bit rp);
    return (sz == 2'd3) && rp && (md == 2'd0 || md == 2'd3);
  endfunction

  function automatic bit [31:0] m_addr(bit [31:0] b, bit [1:0] sz, bit [1:0] md,
                                       bit rp, int k);
    if (sz != 2'd3 || holds(sz, md, rp)) return b;
    return (b & 32'hFFFF_FFF0) + 32'(k * 4);
  endfunction

  function automatic bit [31:0] m_next(bit [31:0] b, bit [1:0] sz, bit [1:0] md, bit rp);
    bit [31:0] n, o;
    n = (sz == 2'd3) ? 32'd16 : (32'd1 << sz);
    o = (sz == 2'd3 && !holds(sz, md, rp)) ? (b & ~32'hF) : b;
    if (md == 2'd1) return o + n;
    if (md == 2'd2) return o - n;
    return b;
  endfunction

  function automatic string tag_for(bit [1:0] sz, bit [1:0] md, bit rp);
    if (sz != 2'd3) return "R3";
    if (holds(sz, md, rp)) return "R5";
    return "R4";
  endfunction

  task automatic run_unit(input bit [1:0] sz, input bit [1:0] sm, input bit [1:0] dm,
                          input bit sr, input bit dr, input bit [31:0] sb,
                          input bit [31:0] db, input bit inject, input string note);
    bit [15:0] w;
    bit [31:0] es, ed;
    int nb, rc, wc, cyc;
    w = 16'($urandom);
    w[1:0] = sz; w[3:2] = sm; w[5:4] = dm; w[8] = sr; w[9] = dr;
    es = m_next(sb, sz, sm, sr);
    ed = m_next(db, sz, dm, dr);
    nb = (sz == 2'd3) ? 4 : 1;
    @(negedge clk);
    ctrl_we = 1'b1; ctrl_wdata = w; base_we = 1'b1; src_base_in = sb; dst_base_in = db;
    @(negedge clk);
    ctrl_we = 1'b0; base_we = 1'b0;
    chk(ctrl_rdata == (w & 16'h033F), "R2 ctrl readback masks reserved bits", 32'(ctrl_rdata),
        32'(w & 16'h033F));
    chk(src_base == sb && dst_base == db, "R10 base load while idle", src_base, sb);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    rc = 0; wc = 0; cyc = 0;
    while (wc < nb) begin
      start = 1'b0; base_we = 1'b0;
      chk(!done && busy, "R9 no done/busy drop mid-unit", {30'd0, done, busy}, 32'd1);
      if (rc < nb) begin
        chk(rd_valid && !wr_valid, "R8 reads precede writes", {30'd0, rd_valid, wr_valid}, 32'd2);
        chk(rd_addr == m_addr(sb, sz, sm, sr, rc),
            $sformatf("%s %s rd beat %0d", tag_for(sz, sm, sr), note, rc),
            rd_addr, m_addr(sb, sz, sm, sr, rc));
        rd_ready = ($urandom % 3) != 0;
        wr_ready = $urandom % 2;
        if (rd_ready) rc++;
      end else begin
        chk(wr_valid && !rd_valid, "R8 writes after reads", {30'd0, rd_valid, wr_valid}, 32'd1);
        chk(wr_addr == m_addr(db, sz, dm, dr, wc),
            $sformatf("%s %s wr beat %0d", tag_for(sz, dm, dr), note, wc),
            wr_addr, m_addr(db, sz, dm, dr, wc));
        wr_ready = ($urandom % 3) != 0;
        rd_ready = $urandom % 2;
        if (wr_ready) wc++;
      end
      if (inject && cyc == 1) begin
        start = 1'b1; base_we = 1'b1;
        src_base_in = 32'hDEAD_BEEF; dst_base_in = 32'hBAD0_F00D;
      end
      cyc++;
      @(negedge clk);
    end
    start = 1'b0; base_we = 1'b0; rd_ready = 1'b0; wr_ready = 1'b0;
    chk(done && busy && !rd_valid && !wr_valid, "R9 done pulse after last write",
        {29'd0, done, busy, rd_valid | wr_valid}, 32'd6);
    @(negedge clk);
    chk(!done && !busy && !rd_valid, "R9 R11 done single cycle, idle after unit",
        {29'd0, done, busy, rd_valid}, 32'd0);
    chk(src_base == es, $sformatf("R10 %s source base update", note), src_base, es);
    chk(dst_base == ed, $sformatf("R10 %s destination base update", note), dst_base, ed);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !rd_valid && !wr_valid && !done, "R1 idle after reset",
        {28'd0, busy, rd_valid, wr_valid, done}, 32'd0);
    chk(ctrl_rdata == 16'd0, "R1 ctrl reset", 32'(ctrl_rdata), 32'd0);
    chk(src_base == 0 && dst_base == 0, "R1 bases reset", src_base | dst_base, 32'd0);

    // Directed corners
    run_unit(2'd3, 2'd0, 2'd0, 1'b0, 1'b1, 32'h0000_1003, 32'h4000_0020, 1'b0, "unaligned step vs R7 repeat");
    run_unit(2'd3, 2'd0, 2'd0, 1'b1, 1'b0, 32'h2000_0008, 32'h0000_300C, 1'b0, "R7 repeat vs step");
    run_unit(2'd3, 2'd1, 2'd2, 1'b0, 1'b0, 32'h0000_0105, 32'h0000_0007, 1'b0, "inc/dec aligned");
    run_unit(2'd3, 2'd2, 2'd1, 1'b1, 1'b1, 32'h0000_0010, 32'hFFFF_FFF4, 1'b0, "R6 flag ignored non-fixed");
    run_unit(2'd0, 2'd0, 2'd0, 1'b1, 1'b1, 32'h0000_0003, 32'h0000_0005, 1'b0, "R6 flag ignored small size");
    run_unit(2'd1, 2'd1, 2'd2, 1'b0, 1'b0, 32'h0000_0101, 32'h0000_0000, 1'b1, "R11 half-word");
    run_unit(2'd2, 2'd2, 2'd1, 1'b1, 1'b0, 32'h0000_0004, 32'h0000_0FFD, 1'b1, "R11 word");
    run_unit(2'd3, 2'd0, 2'd0, 1'b1, 1'b1, 32'h0000_5557, 32'h0000_999B, 1'b1, "R5 R11 both repeat");

    // Constrained random units
    for (int i = 0; i < 60; i++) begin
      run_unit(2'($urandom), 2'($urandom % 3), 2'($urandom % 3), 1'($urandom),
               1'($urandom), $urandom, $urandom, ($urandom % 3) == 0, "random");
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule